// File: doc/BRIEF.md
# Integer Compare and Byte-Pattern Unit

This unit serves the integer datapath of a small RISC-style processor. It takes two operands, `opa` and `opb`, and a 2-bit operation code. It returns one of three results:

- a signed ordering word;
- an unsigned ordering word;
- the position of the first byte lane in which the two operands agree.

Both ordering words start from the difference `opb - opa`, formed as `opb + ~opa + 1`. When the operand sign bits differ, bit 31 of the difference is overwritten so that it shows the correct ordering. The lower bits keep the raw difference.

The caller pulses `start` for one cycle with the operands and the code applied. On the next clock edge the result is registered and `valid` is high for exactly that one cycle. Between operations the result register holds its last value. The byte search scans from the most significant lane toward the least significant lane. It reports a one-based index, so 1 means bits 31:24, and 0 means that no lane matched.

Top module: `cmp_unit`

## Requirements
- R1: With op code 00 (signed) or 01 (unsigned), when bit 31 of `opa` equals bit 31 of `opb`, the result is the raw 32-bit difference `opb + ~opa + 1`.
- R2: With op code 00 (signed), when bit 31 of the two operands differ, result bit 31 equals bit 31 of `opb` and bits 30:0 equal bits 30:0 of the difference; result bit 31 is then set exactly when `opb < opa` as signed numbers.
- R3: With op code 01 (unsigned), when bit 31 of the two operands differ, result bit 31 equals bit 31 of `opa` and bits 30:0 equal bits 30:0 of the difference; result bit 31 is then set exactly when `opb < opa` as unsigned numbers.
- R4: With op code 10 (byte pattern), the lanes are tested in the order bits 31:24 (index 1), 23:16 (index 2), 15:8 (index 3) and 7:0 (index 4). The result is the zero-extended index of the first lane whose bytes are equal.
- R5: With op code 10, when no lane matches, the result is 0.
- R6: Op code 11 is reserved and produces a result of 0.
- R7: The result and `valid` update on the clock edge that samples `start` high. `valid` is low after any edge that samples `start` low. On such an edge the result keeps its previous value.
- R8: Reset is synchronous and active low. An edge that samples `rst_n` low clears the result to 0 and `valid` to 0, and this overrides `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; operands and code are sampled on this edge |
| op | input | 2 | Operation: 00 signed, 01 unsigned, 10 byte pattern, 11 reserved |
| opa | input | 32 | First operand (subtrahend) |
| opb | input | 32 | Second operand (minuend) |
| result | output | 32 | Registered result |
| valid | output | 1 | High for one cycle when `result` carries a new value |

## Verification
The bench builds the unit with the default parameter values: a 32-bit word split into four 8-bit lanes. At this size every byte-search index from 0 to 4 can be reached with hand-picked operands. Operand pairs with differing sign bits can also be chosen directly, so the bit-31 correction is exercised in both directions for the signed and the unsigned code. Random operand pairs add further sign-mixed and sign-equal cases. Random operands seldom contain equal bytes, so the byte-search indices are covered mainly by the hand-picked operands.

// File: rtl/cmp_pkg.sv
// Package: shared operation codes for the compare unit.
// Assumes: a 2-bit operation field driven by the instruction decoder.
package cmp_pkg;

    typedef enum logic [1:0] {
        OP_SCMP = 2'b00,
        OP_UCMP = 2'b01,
        OP_BYTE = 2'b10,
        OP_RSVD = 2'b11
    } cmp_op_e;

endpackage

// File: rtl/cmp_subtract.sv
// Module: cmp_subtract
// Forms opb - opa as opb + ~opa + 1. It also produces two corrected words
// (signed and unsigned) whose top bit shows the ordering when the operand
// sign bits differ.
// Assumes: purely combinational; the parent registers the outputs.
module cmp_subtract #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res_signed,
    output logic [DATA_W-1:0] res_unsigned
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              sign_split;

    // Raw difference through the inverted-add path.
    always_comb begin
        diff       = opb + ~opa + {{(DATA_W-1){1'b0}}, 1'b1};
        sign_split = opa[MSB] ^ opb[MSB];
    end

    // Overwrite the top bit only when the operand signs differ.
    always_comb begin
        res_signed   = diff;
        res_unsigned = diff;
        if (sign_split) begin
            res_signed[MSB]   = opb[MSB];
            res_unsigned[MSB] = opa[MSB];
        end
    end

    // Ordering checks stated from the arithmetic, not from the bit mux.
    always_comb begin
        p_equal_sign_r1: assert (sign_split || (res_signed == opb - opa && res_unsigned == opb - opa));
        p_signed_order_r2: assert (res_signed[MSB] == ($signed(opb) < $signed(opa)));
        p_unsigned_order_r3: assert (!sign_split || (res_unsigned[MSB] == (opb < opa)));
    end

endmodule

// File: rtl/cmp_lane_search.sv
// Module: cmp_lane_search
// Finds the first lane, scanning from the most significant lane downward,
// in which the two operands hold equal values. Returns a one-based index,
// or 0 when no lane matches.
// Assumes: DATA_W is a whole multiple of LANE_W; combinational.
module cmp_lane_search #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NUM_LANES = DATA_W / LANE_W,
    localparam int IDX_W = $clog2(NUM_LANES + 1)
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [IDX_W-1:0]  lane_idx
);

    // lane_eq[k] covers lane k counted from the top (k = 0 is the MSB lane).
    logic [NUM_LANES-1:0] lane_eq;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int LO = (NUM_LANES - 1 - k) * LANE_W;
        // Per-lane equality detector.
        assign lane_eq[k] = (opa[LO +: LANE_W] == opb[LO +: LANE_W]);
    end

    // Priority pick: the lowest k (most significant lane) wins.
    always_comb begin
        lane_idx = '0;
        for (int k = NUM_LANES - 1; k >= 0; k--) begin
            if (lane_eq[k]) lane_idx = IDX_W'(k + 1);
        end
    end

    // The reported lane really matches, and no earlier lane matches.
    always_comb begin
        if (lane_idx != '0) begin
            p_lane_match_r4: assert (opa[(NUM_LANES - int'(lane_idx)) * LANE_W +: LANE_W]
                                  == opb[(NUM_LANES - int'(lane_idx)) * LANE_W +: LANE_W]);
        end
        for (int j = 1; j <= NUM_LANES; j++) begin
            if (lane_idx == '0 || j < int'(lane_idx)) begin
                p_no_earlier_r5: assert (opa[(NUM_LANES - j) * LANE_W +: LANE_W]
                                      != opb[(NUM_LANES - j) * LANE_W +: LANE_W]);
            end
        end
    end

endmodule

// File: rtl/cmp_unit.sv
// Module: cmp_unit (top)
// Selects the signed compare, unsigned compare or byte-lane search result
// according to op. The result is registered with a one-cycle valid strobe
// one clock after start.
// Assumes: synchronous active-low reset; op is held with start.
module cmp_unit #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              valid
);
    import cmp_pkg::*;

    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int IDX_W     = $clog2(NUM_LANES + 1);

    logic [DATA_W-1:0] res_s, res_u, next_res;
    logic [IDX_W-1:0]  idx;
    cmp_op_e           op_e;

    cmp_subtract #(.DATA_W(DATA_W)) i_sub (
        .opa(opa), .opb(opb), .res_signed(res_s), .res_unsigned(res_u)
    );

    cmp_lane_search #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_lane (
        .opa(opa), .opb(opb), .lane_idx(idx)
    );

    // Choose the result for the requested operation.
    always_comb begin
        op_e = cmp_op_e'(op);
        case (op_e)
            OP_SCMP: next_res = res_s;
            OP_UCMP: next_res = res_u;
            OP_BYTE: next_res = {{(DATA_W-IDX_W){1'b0}}, idx};
            default: next_res = '0;
        endcase
    end

    // Result register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) result <= next_res;
        end
    end

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!valid && $stable(result)));
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b11) |=> (result == '0));
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !valid));

endmodule

// File: tb/test_cmp_unit.sv
module test_cmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    cmp_unit i_cmp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .result(result), .valid(valid)
    );

    // {op, opa, opb, expected}
    localparam logic [97:0] VECS [0:14] = '{
        {2'd0, 32'h00000005, 32'h00000003, 32'hFFFFFFFE},  // R1
        {2'd1, 32'h00000005, 32'h00000003, 32'hFFFFFFFE},  // R1
        {2'd0, 32'h00000003, 32'h00000005, 32'h00000002},  // R1
        {2'd0, 32'h80000000, 32'h00000001, 32'h00000001},  // R2
        {2'd1, 32'h80000000, 32'h00000001, 32'h80000001},  // R3
        {2'd0, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFE},  // R2
        {2'd1, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFE},  // R3
        {2'd0, 32'h7FFFFFFF, 32'h80000000, 32'h80000001},  // R2
        {2'd1, 32'h7FFFFFFF, 32'h80000000, 32'h00000001},  // R3
        {2'd2, 32'h12345678, 32'h12000000, 32'h00000001},  // R4
        {2'd2, 32'h11223344, 32'h00223300, 32'h00000002},  // R4
        {2'd2, 32'h11223344, 32'h00003300, 32'h00000003},  // R4
        {2'd2, 32'h11223344, 32'h00000044, 32'h00000004},  // R4
        {2'd2, 32'h11223344, 32'h44332211, 32'h00000000},  // R5
        {2'd3, 32'hDEADBEEF, 32'h00000001, 32'h00000000}   // R6
    };

    function automatic string req_of(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] e);
        if (o == 2'd3) return "R6";
        if (o == 2'd2) return (e == 0) ? "R5" : "R4";
        if (a[31] == b[31]) return "R1";
        return (o == 2'd0) ? "R2" : "R3";
    endfunction

    // Model built from the requirement text.
    function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d = b + ~a + 32'd1;
        case (o)
            2'd0: begin if (a[31] != b[31]) d[31] = b[31]; return d; end
            2'd1: begin if (a[31] != b[31]) d[31] = a[31]; return d; end
            2'd2: begin
                for (int k = 1; k <= 4; k++)
                    if (a[(4-k)*8 +: 8] == b[(4-k)*8 +: 8]) return 32'(k);
                return 32'd0;
            end
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation: start at a negedge, sample the output one negedge later.
    task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp, input string req);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check(req, result, exp);
        check("R7", {31'd0, valid}, 32'd1);
    endtask

    initial begin
        logic [31:0] held;
        repeat (2) @(negedge clk);
        check("R8", result, 32'd0);
        check("R8", {31'd0, valid}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            run(VECS[i][97:96], VECS[i][95:64], VECS[i][63:32], VECS[i][31:0],
                req_of(VECS[i][97:96], VECS[i][95:64], VECS[i][63:32], VECS[i][31:0]));
        end

        for (int i = 0; i < 200; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            logic [1:0]  o = 2'($urandom_range(0, 3));
            if (i % 5 == 0) b = {a[31:8], ~a[7:0]};
            run(o, a, b, model(o, a, b), req_of(o, a, b, model(o, a, b)));
        end

        // R7: idle cycles drop valid and keep the result.
        run(2'd0, 32'h0000000A, 32'h00000064, 32'h0000005A, "R1");
        held = result;
        opa = 32'hFFFF0000; opb = 32'h0000FFFF; op = 2'd1;
        @(negedge clk);
        check("R7", {31'd0, valid}, 32'd0);
        check("R7", result, held);
        @(negedge clk);
        check("R7", result, held);

        // R8: reset overrides a start request.
        rst_n = 1'b0; start = 1'b1; op = 2'd0;
        @(negedge clk);
        start = 1'b0;
        check("R8", result, 32'd0);
        check("R8", {31'd0, valid}, 32'd0);
        rst_n = 1'b1;
        run(2'd2, 32'hAABBCCDD, 32'h00BB0000, 32'd2, "R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule